// File: doc/BRIEF.md
# Dual-Bank Cascaded IIR Loop Compensator

This block is a fixed-point loop compensator for a digitally controlled power stage. A signed error sample arrives with a one-cycle strobe. It passes through a second-order IIR section, and that section's result feeds a first-order IIR section. The second section's result, clipped to the output width, becomes the control word. A valid pulse marks it a fixed number of clocks after the strobe. The arithmetic runs on a single shared multiplier, which steps through the eight taps in a fixed order.

The coefficients sit in two register banks. One bank is active and drives every computation. The other bank is idle, and the host can rewrite it while the loop keeps running. A write aimed at the active bank is refused and flagged. The active bank changes only when a sample is accepted, so a sample never uses coefficients from both banks. The change can come from a software swap pulse, which is latched until the next sample. It can also come from a line-class input that names the wanted bank directly. A typical use keeps one tuning for low mains voltage and one for high mains voltage, and a voltage classifier drives the select input. The filter delay elements keep their contents across a bank change.

Top module: `dbank_iir_comp`

## Requirements
- R1: Coefficients are signed Q2.14 at write addresses 0=b0, 1=b1, 2=b2, 3=a1, 4=a2, 5=c0, 6=c1, 7=d1. For each accepted sample x, s = sat_D((b0·x + b1·x' + b2·x'' + a1·s' + a2·s'') >>> 14) and u = sat_O((c0·s + c1·s_prev + d1·u_prev) >>> 14). The primes are the earlier inputs and first-stage results, s_prev and u_prev are the previous results, and the shift is arithmetic (floor).
- R2: sat_D and sat_O clip to the two's-complement range of the data width and the output width. With b0 = c0 = 32767 and x = 32767 the output is 32767, and with x = −32768 it is −32768.
- R3: `out_valid` is a one-cycle pulse. It is high in the 11th cycle after the clock edge that accepted `sample_stb`, which is a latency of 10 edges. `ctrl_out` changes only in that cycle and holds its value otherwise.
- R4: A `sample_stb` that arrives while a sample is still being computed is ignored. It produces no output pulse and changes no filter state.
- R5: Only the active bank's coefficients are used. A write to the idle bank takes effect from the next sample that runs on that bank.
- R6: A write with `wr_en` high and `wr_bank` equal to the current `active_bank` leaves both banks unchanged. It raises `wr_err` for exactly the following cycle. A write to the other bank never raises `wr_err`.
- R7: With `hw_sel_en` low, a `swap_req` pulse is latched. The active bank flips at the next accepted sample, and that sample already uses the new bank. Several pulses before that sample cause one flip. `active_bank` changes at no other time.
- R8: With `hw_sel_en` high, each accepted sample makes `line_sel` the active bank, and `swap_req` is ignored and discarded.
- R9: The delay elements of both stages keep their values across a bank change.
- R10: After reset, bank 0 is active, every coefficient and delay element is zero, and `ctrl_out`, `out_valid` and `wr_err` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_stb | input | 1 | Error sample present on `err_in` |
| err_in | input | DATA_W | Signed error sample |
| wr_en | input | 1 | Coefficient write request |
| wr_bank | input | 1 | Bank targeted by the write |
| wr_addr | input | 3 | Coefficient index (see R1) |
| wr_data | input | COEF_W | Signed Q2.14 coefficient |
| swap_req | input | 1 | Pulse requesting a bank flip |
| hw_sel_en | input | 1 | Bank chosen by `line_sel` instead of swap pulses |
| line_sel | input | 1 | Bank wanted by the line-voltage class |
| ctrl_out | output | OUT_W | Saturated control word |
| out_valid | output | 1 | New control word pulse |
| wr_err | output | 1 | Previous cycle's write hit the active bank |
| active_bank | output | 1 | Bank currently used by the filter |

## Verification
The bench runs an integer model of the filter and the bank logic alongside the design and compares it with the design on every clock. Directed cases cover several corner cases:
- a swap followed by samples on an integrator, where a design that cleared its state would restart the sum from zero;
- two swap pulses before one sample, where a toggle-per-pulse design would land on the original bank;
- a write to the active bank, where a design that accepted it would change the gain at once;
- a strobe during computation, where a design that accepted it would emit a second pulse and shift its history;
- full-scale inputs at both signs, where wrap-around instead of clipping gives the opposite sign;
- a swap pulse while the line-class select is in control, which must not move the bank.

// File: rtl/dbic_pkg.sv
// Package: constants shared by the dual-bank compensator.
// Assumes coefficients are Q2.14 and that the tap order below is fixed,
// because the engine walks it and the host address map depends on it.
package dbic_pkg;

    localparam int FRAC_BITS = 14;
    localparam int NUM_BANKS = 2;
    localparam int N_COEF    = 8;
    localparam int TAPS_S1   = 5;
    localparam int TAPS_S2   = 3;
    // one cycle per tap, plus one resolve cycle per stage
    localparam int LATENCY   = TAPS_S1 + TAPS_S2 + 2;

    typedef logic [2:0] coef_addr_t;

    // host-visible coefficient indices
    localparam coef_addr_t CI_B0 = 3'd0;
    localparam coef_addr_t CI_B1 = 3'd1;
    localparam coef_addr_t CI_B2 = 3'd2;
    localparam coef_addr_t CI_A1 = 3'd3;
    localparam coef_addr_t CI_A2 = 3'd4;
    localparam coef_addr_t CI_C0 = 3'd5;
    localparam coef_addr_t CI_C1 = 3'd6;
    localparam coef_addr_t CI_D1 = 3'd7;

    // engine sequence steps
    typedef enum logic [3:0] {
        SQ_B0  = 4'd0,
        SQ_B1  = 4'd1,
        SQ_B2  = 4'd2,
        SQ_A1  = 4'd3,
        SQ_A2  = 4'd4,
        SQ_S1  = 4'd5,
        SQ_C0  = 4'd6,
        SQ_C1  = 4'd7,
        SQ_D1  = 4'd8,
        SQ_OUT = 4'd9
    } seq_t;

endpackage

// File: rtl/dbic_bank_ctrl.sv
// Module: bank selection for the compensator.
// Holds the active bank index. The index moves only on an accepted sample
// strobe (start), either by a latched software swap or by the line-class
// select when hardware selection is enabled.
module dbic_bank_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic swap_req,
    input  logic hw_sel_en,
    input  logic line_sel,
    output logic act_bank
);

    logic pend_q;
    logic act_q;

    // Latch swap requests and apply the bank change at a sample boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            pend_q <= 1'b0;
        end else if (start) begin
            if (hw_sel_en) begin
                act_q <= line_sel;
            end else if (pend_q || swap_req) begin
                act_q <= ~act_q;
            end
            pend_q <= 1'b0;
        end else begin
            pend_q <= hw_sel_en ? 1'b0 : (pend_q || swap_req);
        end
    end

    assign act_bank = act_q;

endmodule

// File: rtl/dbic_coef_store.sv
// Module: two banks of filter coefficients with a guarded write port.
// A write is taken only if it targets the bank that is idle in that cycle.
// A write that targets the active bank is dropped and reported one cycle
// later. The read port always returns the active bank's coefficient.
module dbic_coef_store
    import dbic_pkg::*;
#(
    parameter int COEF_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     act_bank,
    input  logic                     wr_en,
    input  logic                     wr_bank,
    input  coef_addr_t               wr_addr,
    input  logic signed [COEF_W-1:0] wr_data,
    input  coef_addr_t               rd_addr,
    output logic signed [COEF_W-1:0] rd_coef,
    output logic                     wr_reject
);

    logic signed [COEF_W-1:0] bank_q [NUM_BANKS][N_COEF];
    logic [NUM_BANKS-1:0]     bank_we;
    logic                     reject_q;

    // per-bank write enable: the bank is addressed and is not the active one
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_we
        assign bank_we[b] = wr_en && (wr_bank == 1'(b)) && (act_bank != 1'(b));
    end

    // Store accepted coefficient writes and clear all banks on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                for (int i = 0; i < N_COEF; i++) begin
                    bank_q[b][i] <= '0;
                end
            end
        end else begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (bank_we[b]) begin
                    bank_q[b][wr_addr] <= wr_data;
                end
            end
        end
    end

    // Flag a refused write for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reject_q <= 1'b0;
        end else begin
            reject_q <= wr_en && (wr_bank == act_bank);
        end
    end

    assign rd_coef   = bank_q[act_bank][rd_addr];
    assign wr_reject = reject_q;

endmodule

// File: rtl/dbic_mac_engine.sv
// Module: sequential multiply-accumulate engine for the cascaded filter.
// One multiplier walks the five taps of the second-order stage, resolves
// and saturates that stage, then walks the three taps of the first-order
// stage and saturates the output. It assumes the coefficient on coef_in
// belongs to coef_addr and stays fixed for the whole sample, which holds
// because the bank cannot change while busy is high.
module dbic_mac_engine
    import dbic_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int OUT_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic signed [DATA_W-1:0] err_in,
    input  logic signed [COEF_W-1:0] coef_in,
    output coef_addr_t               coef_addr,
    output logic                     busy,
    output logic signed [OUT_W-1:0]  ctrl_out,
    output logic                     out_valid
);

    localparam int TAP_W  = (DATA_W > OUT_W) ? DATA_W : OUT_W;
    localparam int PROD_W = TAP_W + COEF_W;
    localparam int ACC_W  = PROD_W + 3;

    localparam logic signed [ACC_W-1:0] D_MAX = {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] D_MIN = {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
    localparam logic signed [ACC_W-1:0] O_MAX = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] O_MIN = {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    seq_t                     step_q;
    logic                     busy_q;
    logic                     valid_q;
    logic signed [ACC_W-1:0]  acc_q;
    logic signed [DATA_W-1:0] x0_q, x1_q, x2_q;
    logic signed [DATA_W-1:0] y1_q, y2_q;
    logic signed [DATA_W-1:0] s_cur_q, s_prev_q;
    logic signed [OUT_W-1:0]  u_q;

    logic signed [TAP_W-1:0]  tap;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  acc_sum;
    logic signed [DATA_W-1:0] s_new;
    logic signed [OUT_W-1:0]  u_new;

    // rescale the accumulator and clip it to the data width
    function automatic logic signed [DATA_W-1:0] sat_data(input logic signed [ACC_W-1:0] a);
        logic signed [ACC_W-1:0] sh;
        sh = a >>> FRAC_BITS;
        if (sh > D_MAX) begin
            return D_MAX[DATA_W-1:0];
        end else if (sh < D_MIN) begin
            return D_MIN[DATA_W-1:0];
        end
        return sh[DATA_W-1:0];
    endfunction

    // rescale the accumulator and clip it to the output width
    function automatic logic signed [OUT_W-1:0] sat_out(input logic signed [ACC_W-1:0] a);
        logic signed [ACC_W-1:0] sh;
        sh = a >>> FRAC_BITS;
        if (sh > O_MAX) begin
            return O_MAX[OUT_W-1:0];
        end else if (sh < O_MIN) begin
            return O_MIN[OUT_W-1:0];
        end
        return sh[OUT_W-1:0];
    endfunction

    // Pick the coefficient index for the current step.
    always_comb begin
        case (step_q)
            SQ_B0:   coef_addr = CI_B0;
            SQ_B1:   coef_addr = CI_B1;
            SQ_B2:   coef_addr = CI_B2;
            SQ_A1:   coef_addr = CI_A1;
            SQ_A2:   coef_addr = CI_A2;
            SQ_C0:   coef_addr = CI_C0;
            SQ_C1:   coef_addr = CI_C1;
            SQ_D1:   coef_addr = CI_D1;
            default: coef_addr = CI_B0;
        endcase
    end

    // Pick the data tap that pairs with the current coefficient.
    always_comb begin
        case (step_q)
            SQ_B0:   tap = TAP_W'(x0_q);
            SQ_B1:   tap = TAP_W'(x1_q);
            SQ_B2:   tap = TAP_W'(x2_q);
            SQ_A1:   tap = TAP_W'(y1_q);
            SQ_A2:   tap = TAP_W'(y2_q);
            SQ_C0:   tap = TAP_W'(s_cur_q);
            SQ_C1:   tap = TAP_W'(s_prev_q);
            SQ_D1:   tap = TAP_W'(u_q);
            default: tap = '0;
        endcase
    end

    // Form the product, the running sum and both saturated stage results.
    always_comb begin
        prod    = PROD_W'(tap) * PROD_W'(coef_in);
        acc_sum = acc_q + ACC_W'(prod);
        s_new   = sat_data(acc_q);
        u_new   = sat_out(acc_q);
    end

    // Sequence the taps, update the delay lines and emit the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q   <= SQ_B0;
            busy_q   <= 1'b0;
            valid_q  <= 1'b0;
            acc_q    <= '0;
            x0_q     <= '0;
            x1_q     <= '0;
            x2_q     <= '0;
            y1_q     <= '0;
            y2_q     <= '0;
            s_cur_q  <= '0;
            s_prev_q <= '0;
            u_q      <= '0;
        end else begin
            valid_q <= 1'b0;
            if (start) begin
                busy_q <= 1'b1;
                step_q <= SQ_B0;
                acc_q  <= '0;
                x0_q   <= err_in;
            end else if (busy_q) begin
                case (step_q)
                    SQ_S1: begin
                        x2_q    <= x1_q;
                        x1_q    <= x0_q;
                        y2_q    <= y1_q;
                        y1_q    <= s_new;
                        s_cur_q <= s_new;
                        acc_q   <= '0;
                        step_q  <= SQ_C0;
                    end
                    SQ_OUT: begin
                        u_q      <= u_new;
                        s_prev_q <= s_cur_q;
                        valid_q  <= 1'b1;
                        busy_q   <= 1'b0;
                        step_q   <= SQ_B0;
                    end
                    default: begin
                        acc_q  <= acc_sum;
                        step_q <= seq_t'(step_q + 4'd1);
                    end
                endcase
            end
        end
    end

    assign busy      = busy_q;
    assign ctrl_out  = u_q;
    assign out_valid = valid_q;

endmodule

// File: rtl/dbank_iir_comp.sv
// Module: top of the dual-bank cascaded IIR compensator.
// A strobe is accepted only while the engine is idle. The accepting edge
// also applies any pending bank change, so every sample runs on one bank.
// Assumes err_in is valid in the strobe cycle only.
module dbank_iir_comp
    import dbic_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int OUT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_stb,
    input  logic [DATA_W-1:0] err_in,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [2:0]        wr_addr,
    input  logic [COEF_W-1:0] wr_data,
    input  logic              swap_req,
    input  logic              hw_sel_en,
    input  logic              line_sel,
    output logic [OUT_W-1:0]  ctrl_out,
    output logic              out_valid,
    output logic              wr_err,
    output logic              active_bank
);

    logic                     busy_w;
    logic                     start_w;
    logic                     act_w;
    coef_addr_t               coef_addr_w;
    logic signed [COEF_W-1:0] coef_w;
    logic signed [OUT_W-1:0]  ctrl_w;

    assign start_w = sample_stb && !busy_w;

    dbic_bank_ctrl u_bank_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_w),
        .swap_req  (swap_req),
        .hw_sel_en (hw_sel_en),
        .line_sel  (line_sel),
        .act_bank  (act_w)
    );

    dbic_coef_store #(
        .COEF_W (COEF_W)
    ) u_coef_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_bank  (act_w),
        .wr_en     (wr_en),
        .wr_bank   (wr_bank),
        .wr_addr   (wr_addr),
        .wr_data   ($signed(wr_data)),
        .rd_addr   (coef_addr_w),
        .rd_coef   (coef_w),
        .wr_reject (wr_err)
    );

    dbic_mac_engine #(
        .DATA_W (DATA_W),
        .COEF_W (COEF_W),
        .OUT_W  (OUT_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_w),
        .err_in    ($signed(err_in)),
        .coef_in   (coef_w),
        .coef_addr (coef_addr_w),
        .busy      (busy_w),
        .ctrl_out  (ctrl_w),
        .out_valid (out_valid)
    );

    assign ctrl_out    = ctrl_w;
    assign active_bank = act_w;

endmodule

// File: rtl/dbic_checker.sv
// Module: protocol checker for the compensator, bound to the top.
// Watches the strobe-to-output timing with its own counter, the bank
// update rules and the write-refusal flag.
module dbic_checker
    import dbic_pkg::*;
#(
    parameter int OUT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_w,
    input logic             busy_w,
    input logic             out_valid,
    input logic [OUT_W-1:0] ctrl_out,
    input logic             wr_en,
    input logic             wr_bank,
    input logic             wr_err,
    input logic             active_bank,
    input logic             hw_sel_en,
    input logic             line_sel
);

    localparam int CNT_W = $clog2(LATENCY + 2);
    localparam logic [CNT_W-1:0] DONE_CNT = CNT_W'(LATENCY + 1);

    logic [CNT_W-1:0] since_q;

    // Count cycles since the last accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= '0;
        end else if (start_w) begin
            since_q <= CNT_W'(1);
        end else if (since_q != '0 && since_q != DONE_CNT) begin
            since_q <= since_q + CNT_W'(1);
        end else begin
            since_q <= '0;
        end
    end

    // R3
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == (since_q == DONE_CNT));

    // R3
    pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(ctrl_out));

    // R4
    busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q != '0 && since_q != DONE_CNT) |-> busy_w);

    // R6
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_bank == active_bank) |=> wr_err);

    // R6
    reject_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wr_en && wr_bank == active_bank));

    // R7
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_w |=> $stable(active_bank));

    // R8
    hw_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_w && hw_sel_en) |=> active_bank == $past(line_sel));

endmodule

bind dbank_iir_comp dbic_checker #(
    .OUT_W (OUT_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_w     (start_w),
    .busy_w      (busy_w),
    .out_valid   (out_valid),
    .ctrl_out    (ctrl_out),
    .wr_en       (wr_en),
    .wr_bank     (wr_bank),
    .wr_err      (wr_err),
    .active_bank (active_bank),
    .hw_sel_en   (hw_sel_en),
    .line_sel    (line_sel)
);

// File: tb/dbank_iir_comp_tb_top.sv
// Bench: directed cases followed by random traffic, all compared every
// clock against a behavioural integer model of the compensator.
module dbank_iir_comp_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_stb = 1'b0;
    logic [15:0] err_in = '0;
    logic        wr_en = 1'b0;
    logic        wr_bank = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        swap_req = 1'b0;
    logic        hw_sel_en = 1'b0;
    logic        line_sel = 1'b0;
    logic [15:0] ctrl_out;
    logic        out_valid;
    logic        wr_err;
    logic        active_bank;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit cmp_on  = 1'b0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    dbank_iir_comp dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_stb  (sample_stb),
        .err_in      (err_in),
        .wr_en       (wr_en),
        .wr_bank     (wr_bank),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .swap_req    (swap_req),
        .hw_sel_en   (hw_sel_en),
        .line_sel    (line_sel),
        .ctrl_out    (ctrl_out),
        .out_valid   (out_valid),
        .wr_err      (wr_err),
        .active_bank (active_bank)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int sat16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    // ---------------- reference model ----------------
    int mc [2][8];
    int m_act, m_cnt, m_res;
    bit m_pend;
    int mx1, mx2, my1, my2, ms_prev, mu;
    bit e_valid, e_err;
    int e_out;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (mc[b, i]) mc[b][i] = 0;
            m_act = 0; m_cnt = 0; m_res = 0; m_pend = 0;
            mx1 = 0; mx2 = 0; my1 = 0; my2 = 0; ms_prev = 0; mu = 0;
            e_valid = 0; e_err = 0; e_out = 0;
        end else begin
            e_valid = 0;
            e_err = wr_en && (int'(wr_bank) == m_act);
            if (wr_en && int'(wr_bank) != m_act)
                mc[wr_bank][wr_addr] = int'($signed(wr_data));
            if (m_cnt == 1) begin
                e_valid = 1;
                e_out = m_res;
            end
            if (m_cnt != 0) begin
                m_cnt--;
                m_pend = hw_sel_en ? 1'b0 : (m_pend || swap_req);
            end else if (sample_stb) begin
                longint a;
                int x, s;
                if (hw_sel_en) m_act = int'(line_sel);
                else if (m_pend || swap_req) m_act = 1 - m_act;
                m_pend = 0;
                x = int'($signed(err_in));
                a = longint'(mc[m_act][0]) * x + longint'(mc[m_act][1]) * mx1
                  + longint'(mc[m_act][2]) * mx2 + longint'(mc[m_act][3]) * my1
                  + longint'(mc[m_act][4]) * my2;
                s = sat16(a >>> 14);
                mx2 = mx1; mx1 = x; my2 = my1; my1 = s;
                a = longint'(mc[m_act][5]) * s + longint'(mc[m_act][6]) * ms_prev
                  + longint'(mc[m_act][7]) * mu;
                mu = sat16(a >>> 14);
                ms_prev = s;
                m_res = mu;
                m_cnt = 10;
            end else begin
                m_pend = hw_sel_en ? 1'b0 : (m_pend || swap_req);
            end
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && cmp_on) begin
            chk("R3 out_valid timing", int'(out_valid), int'(e_valid));
            chk("R1 ctrl_out value", int'($signed(ctrl_out)), e_out);
            chk("R6 wr_err flag", int'(wr_err), int'(e_err));
            chk("R7 active_bank", int'(active_bank), m_act);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr_coef(input int bank, input int addr, input int val);
        wr_en = 1'b1; wr_bank = 1'(bank); wr_addr = 3'(addr); wr_data = 16'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic swap_pulse();
        swap_req = 1'b1;
        @(negedge clk);
        swap_req = 1'b0;
    endtask

    task automatic run_sample(input int x, output int got);
        sample_stb = 1'b1; err_in = 16'(x);
        @(negedge clk);
        sample_stb = 1'b0;
        got = 99999;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (out_valid) begin
                got = int'($signed(ctrl_out));
                break;
            end
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int got, pulses;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        chk("R10 ctrl_out after reset", int'(ctrl_out), 0);
        chk("R10 out_valid after reset", int'(out_valid), 0);
        chk("R10 wr_err after reset", int'(wr_err), 0);
        chk("R10 active_bank after reset", int'(active_bank), 0);
        cmp_on = 1'b1;

        // R10: zero coefficients give zero output
        run_sample(500, got);
        chk("R10 zero coefficients", got, 0);

        // R7 and R1: unity gain on bank 1 after a swap
        wr_coef(1, 0, 16384);
        wr_coef(1, 5, 16384);
        swap_pulse();
        run_sample(1234, got);
        chk("R1 unity gain", got, 1234);
        chk("R7 bank after swap", int'(active_bank), 1);

        // R6: write to the active bank is refused
        wr_coef(1, 0, 8192);
        chk("R6 refusal flag", int'(wr_err), 1);
        run_sample(1000, got);
        chk("R6 refused write has no effect", got, 1000);

        // R7: two pulses collapse to one flip; R9 integrator continues
        wr_coef(0, 0, 16384);
        wr_coef(0, 5, 16384);
        wr_coef(0, 7, 16384);
        swap_pulse();
        swap_pulse();
        run_sample(100, got);
        chk("R7 single flip for two pulses", int'(active_bank), 0);
        chk("R9 state kept across swap", got, 1100);
        run_sample(100, got);
        chk("R1 integrator step", got, 1200);

        // R5: idle-bank write used after the next swap, R9 again
        wr_coef(1, 5, 8192);
        wr_coef(1, 7, 16384);
        swap_pulse();
        run_sample(100, got);
        chk("R5 idle-bank write takes effect", got, 1250);

        // R4: strobe during computation is ignored
        sample_stb = 1'b1; err_in = 16'(300);
        @(negedge clk);
        sample_stb = 1'b0;
        repeat (2) @(negedge clk);
        sample_stb = 1'b1; err_in = 16'(9999);
        @(negedge clk);
        sample_stb = 1'b0;
        pulses = 0;
        got = 0;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (out_valid) begin
                pulses++;
                got = int'($signed(ctrl_out));
            end
        end
        chk("R4 one pulse only", pulses, 1);
        chk("R4 value from first strobe", got, 1400);
        run_sample(0, got);
        chk("R4 no state from ignored strobe", got, 1400);

        // R8: line-class select overrides the swap path
        hw_sel_en = 1'b1;
        line_sel = 1'b0;
        swap_pulse();
        run_sample(0, got);
        chk("R8 bank follows line_sel 0", int'(active_bank), 0);
        wr_coef(1, 0, 32767);
        wr_coef(1, 5, 32767);
        wr_coef(1, 7, 0);
        line_sel = 1'b1;
        run_sample(32767, got);
        chk("R8 bank follows line_sel 1", int'(active_bank), 1);
        chk("R2 positive clip", got, 32767);
        run_sample(-32768, got);
        chk("R2 negative clip", got, -32768);
        swap_pulse();
        run_sample(0, got);
        chk("R8 swap pulse ignored", int'(active_bank), 1);

        // random traffic against the model
        for (int it = 0; it < 4000; it++) begin
            wr_en      = ($urandom % 4) == 0;
            wr_bank    = 1'($urandom % 2);
            wr_addr    = 3'($urandom % 8);
            wr_data    = 16'(int'($urandom_range(0, 16383)) - 8192);
            swap_req   = ($urandom % 12) == 0;
            sample_stb = ($urandom % 6) == 0;
            err_in     = 16'(int'($urandom_range(0, 8000)) - 4000);
            if (it % 700 == 0) hw_sel_en = ~hw_sel_en;
            if (($urandom % 40) == 0) line_sel = ~line_sel;
            @(negedge clk);
        end
        wr_en = 1'b0; swap_req = 1'b0; sample_stb = 1'b0;
        repeat (20) @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule